// File: doc/BRIEF.md
# Pipelined Signed Radix-4 Multiplier

This block multiplies two signed 4-bit two's-complement operands and returns their full signed 8-bit product. It is fully pipelined. A new operand pair may be presented on every clock, and each result leaves exactly nine clocks after its operands went in. A valid flag travels alongside the data, so downstream logic knows which output cycles carry real products.

Internally the work is split into three sections. The first section recodes the multiplier operand two bits at a time with overlapping triplets. Each recoded digit picks zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. A 4-bit operand therefore yields two partial products, and negative multiples are built from an inverted value plus a +1 correction bit. The second section is a carry-save stage. It folds both partial products and the correction bits into one sum vector and one carry vector. The third section resolves those two vectors. The two lowest product bits are settled directly, and the upper six bits go through a pipelined 6-bit carry look-ahead adder whose carry-out is dropped. The register stages are split 3, 1 and 5 across the three sections.

Top module: `booth_mul_pipe`

## Requirements
- R1: For every valid input pair, `out_p` equals the signed product X*Y, encoded as 8-bit two's complement, where X and Y are the 4-bit two's-complement values on `in_x` and `in_y`.
- R2: When `in_valid` is high at a rising clock edge, `out_valid` is high and the matching product is on `out_p` after exactly nine rising edges, counting that edge as the first.
- R3: A new operand pair is accepted on every clock. Back-to-back valid inputs produce back-to-back valid outputs in the same order, with no gaps and no stalls.
- R4: The most negative operands, X = -8 and Y = -8, produce +64 (`out_p` = 8'h40) with no overflow.
- R5: If either operand is 0, the product is 0. If Y = -1, the product is -X; in particular X = -8 with Y = -1 gives +8 (8'h08).
- R6: `rst_n` is a synchronous, active-low reset. A rising edge with `rst_n` low clears every in-flight valid flag. `out_valid` then stays low until nine edges after the next valid input accepted with `rst_n` high.
- R7: An input cycle with `in_valid` low produces an output cycle with `out_valid` low nine edges later. Valid inputs before and after such a bubble keep their results and their timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the valid pipeline |
| in_valid | input | 1 | Marks `in_x`/`in_y` as a pair to be multiplied this cycle |
| in_x | input | 4 | Multiplicand, two's complement |
| in_y | input | 4 | Multiplier (the operand that is recoded), two's complement |
| out_valid | output | 1 | Marks `out_p` as a result |
| out_p | output | 8 | Signed product, two's complement |

## Verification
Every one of the 256 operand pairs is fed back to back. This catches recoding mistakes, such as a wrong triplet decode for the patterns 011 and 100, which would give wrong products only for certain multiplier values. A missing +1 correction would leave negative multiples off by one or four. X = -8 with Y = -8 targets the case where twice the multiplicand is -16: too narrow a sign extension would wrap the result to a negative number instead of +64. Y = -1 and zero operands test the ones'-complement path on its own and the zero multiple. Bubble patterns and a reset in the middle of a full pipeline show whether the valid flag is delayed by the wrong number of stages or survives a reset.

// File: rtl/booth_mul_pkg.sv
`timescale 1ns/1ps
// booth_mul_pkg: shared stage counts and the recoded-digit type for the
// pipelined radix-4 multiplier. Assumes the stage split stays fixed at 3/1/5.
package booth_mul_pkg;

    localparam int PPG_STAGES = 3;
    localparam int CSA_STAGES = 1;
    localparam int FSA_STAGES = 5;
    localparam int PIPE_LAT   = PPG_STAGES + CSA_STAGES + FSA_STAGES;

    // One recoded multiplier digit: magnitude select plus sign.
    typedef struct packed {
        logic neg;  // multiple is negated
        logic one;  // magnitude is 1 * multiplicand
        logic two;  // magnitude is 2 * multiplicand
    } bdig_t;

    // Map an overlapping bit group {hi, mid, lo} onto a signed digit.
    function automatic bdig_t recode(input logic [2:0] grp);
        bdig_t d;
        d = '0;
        case (grp)
            3'b001, 3'b010: d.one = 1'b1;
            3'b011:         d.two = 1'b1;
            3'b100:         begin d.two = 1'b1; d.neg = 1'b1; end
            3'b101, 3'b110: begin d.one = 1'b1; d.neg = 1'b1; end
            default:        d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/booth_ppg.sv
`timescale 1ns/1ps
// booth_ppg: three-stage partial-product generator.
//   stage 1 registers the operands, stage 2 recodes the multiplier into
//   W/2 signed digits, stage 3 forms each selected multiple (inverted when
//   negative), sign-extended to 2W bits and shifted by 2 per digit, and
//   builds the +1 correction vector.
// Assumes W is even and at least 4. Only the valid pipeline is reset.
module booth_ppg
    import booth_mul_pkg::*;
#(
    parameter int W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [W-1:0]                 in_x,
    input  logic [W-1:0]                 in_y,
    output logic                         out_valid,
    output logic [W/2-1:0][2*W-1:0]      out_pp,
    output logic [2*W-1:0]               out_corr
);

    localparam int PW  = 2 * W;
    localparam int NPP = W / 2;

    logic            v1, v2, v3;
    logic [W-1:0]    x1, y1, x2;
    bdig_t           dig_c [NPP];
    bdig_t           dig2  [NPP];
    logic [NPP-1:0]  neg2;
    logic [NPP-1:0][PW-1:0] pp_c;
    logic [PW-1:0]   corr_c;
    logic [PW-1:0]   x_one, x_two;

    // Stage 1: capture the operand pair and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v1 <= 1'b0;
        else        v1 <= in_valid;
    end

    // Stage 1 data: operands are not reset.
    always_ff @(posedge clk) begin
        x1 <= in_x;
        y1 <= in_y;
    end

    // Stage 2 combinational: one digit per pair of multiplier bits.
    for (genvar i = 0; i < NPP; i++) begin : g_recode
        logic lo_bit;
        if (i == 0) begin : g_first
            assign lo_bit = 1'b0;
        end else begin : g_rest
            assign lo_bit = y1[2*i-1];
        end
        assign dig_c[i] = recode({y1[2*i+1], y1[2*i], lo_bit});
    end

    // Stage 2: valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v2 <= 1'b0;
        else        v2 <= v1;
    end

    // Stage 2 data: recoded digits and the multiplicand.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NPP; i++) dig2[i] <= dig_c[i];
        x2 <= x1;
    end

    // Sign-extended one and two times the multiplicand.
    assign x_one = {{(PW-W){x2[W-1]}}, x2};
    assign x_two = {{(PW-W-1){x2[W-1]}}, x2, 1'b0};

    // Stage 3 combinational: select, invert and weight each multiple.
    for (genvar i = 0; i < NPP; i++) begin : g_mult
        logic [PW-1:0] mag;
        assign mag       = dig2[i].one ? x_one : (dig2[i].two ? x_two : '0);
        assign pp_c[i]   = (dig2[i].neg ? ~mag : mag) << (2 * i);
        assign neg2[i]   = dig2[i].neg;
    end

    // Place each digit's +1 correction at its partial product's weight.
    always_comb begin
        corr_c = '0;
        for (int i = 0; i < NPP; i++) corr_c[2*i] = neg2[i];
    end

    // Stage 3: valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) v3 <= 1'b0;
        else        v3 <= v2;
    end

    // Stage 3 data: partial products and corrections.
    always_ff @(posedge clk) begin
        out_pp   <= pp_c;
        out_corr <= corr_c;
    end

    assign out_valid = v3;

endmodule

// File: rtl/csa_reduce.sv
`timescale 1ns/1ps
// csa_reduce: one-stage carry-save reduction of the partial products and
// the correction vector into a sum vector and a carry vector (mod 2^PW).
// Assumes at least one partial product; the correction vector seeds the
// carry input so two partial products need only a single 3:2 row.
module csa_reduce #(
    parameter int NPP = 2,
    parameter int PW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NPP-1:0][PW-1:0]  in_pp,
    input  logic [PW-1:0]           in_corr,
    output logic                    out_valid,
    output logic [PW-1:0]           out_sum,
    output logic [PW-1:0]           out_carry
);

    logic [PW-1:0] sum_c, car_c;
    logic          v_q;

    // Chain of 3:2 compressors, one row per extra partial product.
    always_comb begin
        logic [PW-1:0] s, c, maj;
        s = in_pp[0];
        c = in_corr;
        for (int k = 1; k < NPP; k++) begin
            maj = (s & c) | (s & in_pp[k]) | (c & in_pp[k]);
            s   = s ^ c ^ in_pp[k];
            c   = maj << 1;
        end
        sum_c = s;
        car_c = c;
    end

    // Valid flag for the reduction stage.
    always_ff @(posedge clk) begin
        if (!rst_n) v_q <= 1'b0;
        else        v_q <= in_valid;
    end

    // Register the redundant pair.
    always_ff @(posedge clk) begin
        out_sum   <= sum_c;
        out_carry <= car_c;
    end

    assign out_valid = v_q;

endmodule

// File: rtl/cla_final.sv
`timescale 1ns/1ps
// cla_final: five-stage resolver of the sum/carry pair.
//   stage 1 settles the LOW_W lowest bits directly and passes their carry,
//   stage 2 forms bitwise generate/propagate of the upper bits,
//   stage 3 forms block generate/propagate per BLK-bit group,
//   stage 4 computes every carry with block look-ahead,
//   stage 5 forms the upper sum bits. The final carry-out is dropped.
// Assumes PW > LOW_W. Only the valid pipeline is reset.
module cla_final #(
    parameter int PW    = 8,
    parameter int LOW_W = 2,
    parameter int BLK   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [PW-1:0]   in_sum,
    input  logic [PW-1:0]   in_carry,
    output logic            out_valid,
    output logic [PW-1:0]   out_p
);

    localparam int HI   = PW - LOW_W;
    localparam int NBLK = (HI + BLK - 1) / BLK;

    logic [4:0]        vq;
    logic [LOW_W:0]    low_c;
    logic [HI-1:0]     a1, b1, g2, p2, g3, p3, p4, cv_c, cv4;
    logic              cin1, cin2, cin3;
    logic [LOW_W-1:0]  lo1, lo2, lo3, lo4;
    logic [NBLK-1:0]   bg_c, bp_c, bg3, bp3;

    // Valid flag shifts through all five stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= {vq[3:0], in_valid};
    end

    // Low bits of the pair resolved with a narrow add.
    assign low_c = {1'b0, in_sum[LOW_W-1:0]} + {1'b0, in_carry[LOW_W-1:0]};

    // Stage 1: split off the settled low bits and the upper operands.
    always_ff @(posedge clk) begin
        a1   <= in_sum[PW-1:LOW_W];
        b1   <= in_carry[PW-1:LOW_W];
        cin1 <= low_c[LOW_W];
        lo1  <= low_c[LOW_W-1:0];
    end

    // Stage 2: bitwise generate and propagate.
    always_ff @(posedge clk) begin
        g2   <= a1 & b1;
        p2   <= a1 ^ b1;
        cin2 <= cin1;
        lo2  <= lo1;
    end

    // Block generate/propagate over each group of BLK bits.
    always_comb begin
        for (int b = 0; b < NBLK; b++) begin
            logic gacc, pacc;
            gacc = 1'b0;
            pacc = 1'b1;
            for (int j = 0; j < BLK; j++) begin
                if (b * BLK + j < HI) begin
                    gacc = g2[b*BLK+j] | (p2[b*BLK+j] & gacc);
                    pacc = pacc & p2[b*BLK+j];
                end
            end
            bg_c[b] = gacc;
            bp_c[b] = pacc;
        end
    end

    // Stage 3: register block terms alongside the bit terms.
    always_ff @(posedge clk) begin
        bg3  <= bg_c;
        bp3  <= bp_c;
        g3   <= g2;
        p3   <= p2;
        cin3 <= cin2;
        lo3  <= lo2;
    end

    // Block carries by look-ahead, then bit carries inside each block.
    always_comb begin
        logic cblk, cbit;
        cv_c = '0;
        cblk = cin3;
        for (int b = 0; b < NBLK; b++) begin
            cbit = cblk;
            for (int j = 0; j < BLK; j++) begin
                if (b * BLK + j < HI) begin
                    cv_c[b*BLK+j] = cbit;
                    cbit = g3[b*BLK+j] | (p3[b*BLK+j] & cbit);
                end
            end
            cblk = bg3[b] | (bp3[b] & cblk);
        end
    end

    // Stage 4: register carry-in of every upper bit.
    always_ff @(posedge clk) begin
        cv4 <= cv_c;
        p4  <= p3;
        lo4 <= lo3;
    end

    // Stage 5: final sum bits joined with the settled low bits.
    always_ff @(posedge clk) begin
        out_p <= {p4 ^ cv4, lo4};
    end

    assign out_valid = vq[4];

endmodule

// File: rtl/booth_mul_pipe.sv
`timescale 1ns/1ps
// booth_mul_pipe: top of the pipelined signed multiplier. Chains the
// partial-product generator (3 stages), carry-save reduction (1 stage) and
// carry look-ahead resolver (5 stages). One pair in and one product out
// per clock, with a fixed latency of PIPE_LAT edges.
// Assumes W is even and at least 4.
module booth_mul_pipe
    import booth_mul_pkg::*;
#(
    parameter int W     = 4,
    parameter int LOW_W = 2,
    parameter int BLK   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [W-1:0]     in_x,
    input  logic [W-1:0]     in_y,
    output logic             out_valid,
    output logic [2*W-1:0]   out_p
);

    localparam int PW  = 2 * W;
    localparam int NPP = W / 2;
    localparam int LAT = PIPE_LAT;

    logic                    ppg_v, csa_v;
    logic [NPP-1:0][PW-1:0]  ppg_pp;
    logic [PW-1:0]           ppg_corr, csa_s, csa_c;

    booth_ppg #(.W(W)) u_ppg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .in_y      (in_y),
        .out_valid (ppg_v),
        .out_pp    (ppg_pp),
        .out_corr  (ppg_corr)
    );

    csa_reduce #(.NPP(NPP), .PW(PW)) u_csa (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ppg_v),
        .in_pp     (ppg_pp),
        .in_corr   (ppg_corr),
        .out_valid (csa_v),
        .out_sum   (csa_s),
        .out_carry (csa_c)
    );

    cla_final #(.PW(PW), .LOW_W(LOW_W), .BLK(BLK)) u_cla (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (csa_v),
        .in_sum    (csa_s),
        .in_carry  (csa_c),
        .out_valid (out_valid),
        .out_p     (out_p)
    );

endmodule

// File: rtl/booth_mul_pipe_chk.sv
`timescale 1ns/1ps
// booth_mul_pipe_chk: port-level checker bound to booth_mul_pipe. Keeps its
// own delayed copy of the valid flag and a reference product per stage.
module booth_mul_pipe_chk #(
    parameter int W   = 4,
    parameter int LAT = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [W-1:0]     in_x,
    input logic [W-1:0]     in_y,
    input logic             out_valid,
    input logic [2*W-1:0]   out_p
);

    localparam int PW = 2 * W;

    logic [LAT-1:0] vsh;
    logic [PW-1:0]  psh [LAT];
    logic [W-1:0]   xsh [LAT];
    logic [W-1:0]   ysh [LAT];
    logic [PW-1:0]  prod_in, neg_x_out;
    int unsigned    since;

    // Reference product of the incoming pair at full width.
    assign prod_in = PW'($signed({{W{in_x[W-1]}}, in_x}) * $signed({{W{in_y[W-1]}}, in_y}));
    assign neg_x_out = PW'(0) - {{W{xsh[LAT-1][W-1]}}, xsh[LAT-1]};

    // Delayed valid flag and edges since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsh   <= '0;
            since <= 0;
        end else begin
            vsh   <= {vsh[LAT-2:0], in_valid};
            since <= (since < LAT) ? since + 1 : since;
        end
    end

    // Delayed operands and reference products.
    always_ff @(posedge clk) begin
        psh[0] <= prod_in;
        xsh[0] <= in_x;
        ysh[0] <= in_y;
        for (int i = 1; i < LAT; i++) begin
            psh[i] <= psh[i-1];
            xsh[i] <= xsh[i-1];
            ysh[i] <= ysh[i-1];
        end
    end

    // R2, R3, R7: output valid follows input valid by exactly LAT edges.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vsh[LAT-1]);

    // R6: nothing valid can emerge before LAT edges after reset.
    a_r6_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (since < LAT) |-> !out_valid);

    // R1: each valid output is the signed product of its pair.
    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vsh[LAT-1]) |-> (out_p == psh[LAT-1]));

    // R4: most negative operands give the positive power of two.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vsh[LAT-1] && xsh[LAT-1] == {1'b1, {(W-1){1'b0}}}
                                 && ysh[LAT-1] == {1'b1, {(W-1){1'b0}}})
        |-> (out_p == (PW'(1) << (PW - 2))));

    // R5: a zero operand gives zero.
    a_r5_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vsh[LAT-1] && (xsh[LAT-1] == '0 || ysh[LAT-1] == '0))
        |-> (out_p == '0));

    // R5: a multiplier of -1 negates the multiplicand.
    a_r5_minus_one: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && vsh[LAT-1] && ysh[LAT-1] == '1) |-> (out_p == neg_x_out));

endmodule

bind booth_mul_pipe booth_mul_pipe_chk #(.W(W), .LAT(LAT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_y      (in_y),
    .out_valid (out_valid),
    .out_p     (out_p)
);

// File: tb/booth_mul_pipe_test.sv
`timescale 1ns/1ps
// booth_mul_pipe_test: behavioural reference pipeline compared every clock.
module booth_mul_pipe_test;

    localparam int W   = 4;
    localparam int PW  = 2 * W;
    localparam int LAT = 9;
    localparam real HALF = 10.0;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [W-1:0]  in_x, in_y;
    logic          out_valid;
    logic [PW-1:0] out_p;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    string vtag  = "R2";

    logic mv [LAT];
    int   mx [LAT];
    int   my [LAT];

    always #(HALF) clk = ~clk;

    booth_mul_pipe uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .in_y      (in_y),
        .out_valid (out_valid),
        .out_p     (out_p)
    );

    task automatic check_eq(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare outputs with the tail of the reference pipeline.
    task automatic compare();
        int e;
        string ptag;
        check_eq(vtag, int'(out_valid === 1'b1), int'(mv[LAT-1]), "out_valid");
        if (mv[LAT-1]) begin
            e = mx[LAT-1] * my[LAT-1];
            if (mx[LAT-1] == -8 && my[LAT-1] == -8) ptag = "R4";
            else if (mx[LAT-1] == 0 || my[LAT-1] == 0 || my[LAT-1] == -1) ptag = "R5";
            else ptag = "R1";
            check_eq(ptag, int'($signed(out_p)), e, "out_p");
        end
    endtask

    // One clock: check, drive, advance the reference as the edge will.
    task automatic cycle(input bit v, input int x, input int y, input bit r);
        compare();
        in_valid = v;
        in_x     = x[W-1:0];
        in_y     = y[W-1:0];
        rst_n    = r;
        for (int i = LAT - 1; i > 0; i--) begin
            mv[i] = mv[i-1];
            mx[i] = mx[i-1];
            my[i] = my[i-1];
        end
        mv[0] = v;
        mx[0] = x;
        my[0] = y;
        if (!r) for (int i = 0; i < LAT; i++) mv[i] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        int cx [5] = '{-8, 0, -8, 6, 7};
        int cy [5] = '{-8, 5, -1, -1, 0};
        for (int i = 0; i < LAT; i++) begin mv[i] = 1'b0; mx[i] = 0; my[i] = 0; end
        rst_n = 1'b0; in_valid = 1'b0; in_x = '0; in_y = '0;
        repeat (3) @(negedge clk);
        // R6: held in reset, nothing is valid.
        check_eq("R6", int'(out_valid === 1'b1), 0, "out_valid in reset");
        for (int i = 0; i < 4; i++) cycle(1'b0, 0, 0, 1'b1);

        // R2: single pair, count edges to its result.
        vtag = "R2";
        cycle(1'b1, 3, -2, 1'b1);
        lat = 1;
        while (out_valid !== 1'b1 && lat < 20) begin
            cycle(1'b0, 0, 0, 1'b1);
            lat++;
        end
        check_eq("R2", lat, LAT, "latency");
        for (int i = 0; i < 10; i++) cycle(1'b0, 0, 0, 1'b1);

        // R1, R3: all pairs back to back.
        vtag = "R3";
        for (int x = -8; x < 8; x++)
            for (int y = -8; y < 8; y++)
                cycle(1'b1, x, y, 1'b1);
        for (int i = 0; i < 10; i++) cycle(1'b0, 0, 0, 1'b1);

        // R7, R4, R5: corner pairs with bubbles between them.
        vtag = "R7";
        for (int k = 0; k < 40; k++)
            cycle((k % 3) != 0, cx[k % 5], cy[k % 5], 1'b1);
        for (int i = 0; i < 10; i++) cycle(1'b0, 0, 0, 1'b1);

        // R6: reset with a full pipeline discards everything in flight.
        vtag = "R6";
        for (int i = 0; i < 6; i++) cycle(1'b1, i - 3, 5, 1'b1);
        cycle(1'b0, 0, 0, 1'b0);
        cycle(1'b0, 0, 0, 1'b0);
        for (int i = 0; i < 12; i++) cycle(1'b0, 0, 0, 1'b1);
        vtag = "R2";
        for (int i = 0; i < 5; i++) cycle(1'b1, -1, -8, 1'b1);
        for (int i = 0; i < 12; i++) cycle(1'b0, 0, 0, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule